// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization

This block divides every CAN bit into time quanta. A quantum is one cycle of `tqEn`, which a prescaler outside the block supplies. Each bit has three parts: a sync segment one quantum long, phase segment 1 and phase segment 2. The lengths of both phase segments and the synchronization jump width come from input ports. The block emits a one-cycle transmit strobe where each bit begins and a one-cycle sample strobe at the boundary between the two phase segments. At the sample strobe the sampled bit is updated, either from one sample or from a majority vote over three samples.

The block keeps its bit grid aligned with the line. A recessive-to-dominant edge while the bus is idle causes a hard synchronization. When the bus is busy, the same kind of edge causes a resynchronization whose size is capped by the jump width. A wrong combination of parameters raises a configuration error and holds the block quiet. Frame decoding, bit stuffing, prescaling and error counting are outside this block.

Top module: `canBitTiming`

## Requirements
- R1: `cfgErr` is 1 exactly when `ps1Len` (binary quanta) is outside 4..16, `ps2Len` is outside 2..8, `sjwLen` is outside 1..4, or `sjwLen` exceeds `ps2Len`.
- R2: With no falling edges on the line, the bit period is 1+ps1+ps2 quanta. `samplePoint` pulses for one clock after the `tqEn` that closes the ps1-th quantum after the sync quantum. `txPoint` pulses for one clock after the `tqEn` that closes the last quantum of phase segment 2, which is where the next sync segment begins.
- R3: An edge is `rxLine` at 1 on the previous `tqEn` and at 0 on this one. If an edge is seen while `busIdle` is 1, the quantum just closed becomes the sync quantum. The next sample point follows ps1 quanta later.
- R4: With `tripleSample`=0, `rxBit` takes the value of `rxLine` at the `tqEn` that closes phase segment 1. At all other times `rxBit` holds its value.
- R5: With `tripleSample`=1, `rxBit` is the majority of `rxLine` at the sample-point `tqEn` and at the two `tqEn` edges before it.
- R6: An edge seen in quantum k of phase segment 1 lengthens that segment by min(k, sjw). An edge in the sync quantum causes no adjustment.
- R7: An edge in quantum k of phase segment 2 has error e = ps2-k+1. If e <= sjw, the quantum just closed is taken as the sync quantum: `txPoint` pulses and phase segment 1 starts at once. Otherwise phase segment 2 is shortened by sjw.
- R8: At most one resynchronization takes place between two sample points. After a hard synchronization, none takes place before the next sample point.
- R9: While `txDominant` is 1, no resynchronization takes place.
- R10: While `cfgErr` is 1, `samplePoint` and `txPoint` stay 0.
- R11: After reset, both strobes are 0 and `rxBit` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tqEn | input | 1 | One-cycle pulse that closes each time quantum |
| rxLine | input | 1 | Receive line, 1 = recessive |
| busIdle | input | 1 | Bus is idle, so an edge causes a hard synchronization |
| txDominant | input | 1 | This node is currently driving a dominant bit |
| tripleSample | input | 1 | Selects the three-sample majority vote |
| ps1Len | input | 5 | Phase segment 1 length in quanta |
| ps2Len | input | 4 | Phase segment 2 length in quanta |
| sjwLen | input | 3 | Synchronization jump width in quanta |
| rxBit | output | 1 | Sampled bit value |
| txPoint | output | 1 | Bit start strobe |
| samplePoint | output | 1 | Sample strobe |
| cfgErr | output | 1 | Illegal timing parameters |

## Verification
The period test sweeps every legal pair of phase segments with a quiet line. Placing both strobes correctly in each case separates an off-by-one error in either segment from a missing sync quantum. The sampling test applies all eight three-bit line patterns in both sampling modes, which distinguishes a majority vote from a single sample and shows which quanta feed the vote. Edges are then swept across each quantum of phase segment 1 and phase segment 2 for every jump width, which tells a capped correction from an uncapped or missing one. Extra edges and edges during a dominant transmit show whether the one-resynchronization rule and the suppression rule hold. Illegal parameter sets are applied one by one at each limit.

// File: rtl/canBtPkg.sv
package canBtPkg;
  typedef enum logic [1:0] {SEG_SYNC, SEG_PS1, SEG_PS2} btSeg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeSample;
    logic useVote;
  } btStrobe_t;
endpackage

// File: rtl/canBtData.sv
module canBtData
  import canBtPkg::*;
#(
  parameter bit ALLOW_VOTE = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tqEn,
  input  logic      rxLine,
  input  btStrobe_t strobe,
  output logic      edgeSeen,
  output logic      rxBit
);
  // line value at the last two quantum ends; [0] is the most recent
  logic [1:0] hist;
  logic       voteBit;
  logic       newBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hist <= 2'b11;
    else if (tqEn) hist <= {hist[0], rxLine};
  end

  assign edgeSeen = tqEn && hist[0] && !rxLine;

  generate
    if (ALLOW_VOTE) begin : g_vote
      assign voteBit = (hist[1] & hist[0]) | (hist[1] & rxLine) | (hist[0] & rxLine);
    end else begin : g_novote
      assign voteBit = rxLine;
    end
  endgenerate

  assign newBit = strobe.useVote ? voteBit : rxLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxBit <= 1'b1;
    else if (strobe.takeSample) rxBit <= newBit;
  end

  // R4
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeSample |=> $stable(rxBit));
endmodule

// File: rtl/canBtCtrl.sv
module canBtCtrl
  import canBtPkg::*;
#(
  parameter int PS1_MIN = 4,
  parameter int PS1_MAX = 16,
  parameter int PS2_MIN = 2,
  parameter int PS2_MAX = 8,
  parameter int SJW_MAX = 4,
  parameter int P1W = $clog2(PS1_MAX + 1),
  parameter int P2W = $clog2(PS2_MAX + 1),
  parameter int SW  = $clog2(SJW_MAX + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           tqEn,
  input  logic           busIdle,
  input  logic           txDominant,
  input  logic           tripleSample,
  input  logic           edgeSeen,
  input  logic [P1W-1:0] ps1Len,
  input  logic [P2W-1:0] ps2Len,
  input  logic [SW-1:0]  sjwLen,
  output btStrobe_t      strobe,
  output logic           txPoint,
  output logic           samplePoint,
  output logic           cfgErr
);
  localparam int CW = $clog2(PS1_MAX + SJW_MAX + 2);
  localparam logic [CW-1:0] ONE = CW'(1);

  btSeg_e        seg;
  logic [CW-1:0] cnt, ps1End, ps2End;
  logic          resyncDone, spPulse, txPulse;
  logic [CW-1:0] ps1Ext, ps2Ext, sjwExt, step1, end1, end2, remain2;
  logic          hardSync, doResync, earlyJump, endPs1;

  always_comb begin
    ps1Ext = CW'(ps1Len);
    ps2Ext = CW'(ps2Len);
    sjwExt = CW'(sjwLen);
    cfgErr = (ps1Ext < CW'(PS1_MIN)) || (ps1Ext > CW'(PS1_MAX)) ||
             (ps2Ext < CW'(PS2_MIN)) || (ps2Ext > CW'(PS2_MAX)) ||
             (sjwExt < ONE) || (sjwExt > CW'(SJW_MAX)) || (sjwExt > ps2Ext);
    hardSync = edgeSeen && busIdle && !cfgErr;
    doResync = edgeSeen && !busIdle && !txDominant && !resyncDone &&
               (seg != SEG_SYNC) && !cfgErr;
    step1   = (cnt < sjwExt) ? cnt : sjwExt;
    end1    = doResync ? ps1End + step1 : ps1End;
    remain2 = ps2End - cnt + ONE;
    end2    = doResync ? ((ps2End > sjwExt) ? ps2End - sjwExt : ONE) : ps2End;
    earlyJump = doResync && (seg == SEG_PS2) && (remain2 <= sjwExt);
    endPs1  = tqEn && !cfgErr && !hardSync && (seg == SEG_PS1) && (cnt >= end1);
    strobe.takeSample = endPs1;
    strobe.useVote    = tripleSample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seg        <= SEG_SYNC;
      cnt        <= ONE;
      ps1End     <= CW'(PS1_MIN);
      ps2End     <= CW'(PS2_MIN);
      resyncDone <= 1'b0;
      spPulse    <= 1'b0;
      txPulse    <= 1'b0;
    end else begin
      spPulse <= 1'b0;
      txPulse <= 1'b0;
      if (cfgErr) begin
        seg        <= SEG_SYNC;
        cnt        <= ONE;
        resyncDone <= 1'b0;
      end else if (hardSync) begin
        seg        <= SEG_PS1;
        cnt        <= ONE;
        ps1End     <= ps1Ext;
        resyncDone <= 1'b1;
      end else if (tqEn) begin
        case (seg)
          SEG_SYNC: begin
            seg    <= SEG_PS1;
            cnt    <= ONE;
            ps1End <= ps1Ext;
          end
          SEG_PS1: begin
            if (endPs1) begin
              seg        <= SEG_PS2;
              cnt        <= ONE;
              ps2End     <= ps2Ext;
              spPulse    <= 1'b1;
              resyncDone <= 1'b0;
            end else begin
              cnt    <= cnt + ONE;
              ps1End <= end1;
              if (doResync) resyncDone <= 1'b1;
            end
          end
          SEG_PS2: begin
            if (earlyJump) begin
              seg        <= SEG_PS1;
              cnt        <= ONE;
              ps1End     <= ps1Ext;
              txPulse    <= 1'b1;
              resyncDone <= 1'b1;
            end else if (cnt >= end2) begin
              seg     <= SEG_SYNC;
              cnt     <= ONE;
              txPulse <= 1'b1;
              if (doResync) resyncDone <= 1'b1;
            end else begin
              cnt    <= cnt + ONE;
              ps2End <= end2;
              if (doResync) resyncDone <= 1'b1;
            end
          end
          default: seg <= SEG_SYNC;
        endcase
      end
    end
  end

  assign txPoint     = txPulse;
  assign samplePoint = spPulse;

  // R10
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> (!samplePoint && !txPoint));
  // R2
  strobe_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (samplePoint || txPoint) |-> $past(tqEn));
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(samplePoint && txPoint));
  // R3
  hard_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    hardSync |=> (seg == SEG_PS1 && cnt == ONE && resyncDone));
endmodule

// File: rtl/canBitTiming.sv
module canBitTiming
  import canBtPkg::*;
#(
  parameter int PS1_MIN = 4,
  parameter int PS1_MAX = 16,
  parameter int PS2_MIN = 2,
  parameter int PS2_MAX = 8,
  parameter int SJW_MAX = 4,
  parameter bit ALLOW_VOTE = 1'b1,
  parameter int P1W = $clog2(PS1_MAX + 1),
  parameter int P2W = $clog2(PS2_MAX + 1),
  parameter int SW  = $clog2(SJW_MAX + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           tqEn,
  input  logic           rxLine,
  input  logic           busIdle,
  input  logic           txDominant,
  input  logic           tripleSample,
  input  logic [P1W-1:0] ps1Len,
  input  logic [P2W-1:0] ps2Len,
  input  logic [SW-1:0]  sjwLen,
  output logic           rxBit,
  output logic           txPoint,
  output logic           samplePoint,
  output logic           cfgErr
);
  btStrobe_t strobe;
  logic      edgeSeen;

  canBtCtrl #(
    .PS1_MIN(PS1_MIN), .PS1_MAX(PS1_MAX), .PS2_MIN(PS2_MIN), .PS2_MAX(PS2_MAX),
    .SJW_MAX(SJW_MAX), .P1W(P1W), .P2W(P2W), .SW(SW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tqEn(tqEn), .busIdle(busIdle),
    .txDominant(txDominant), .tripleSample(tripleSample), .edgeSeen(edgeSeen),
    .ps1Len(ps1Len), .ps2Len(ps2Len), .sjwLen(sjwLen), .strobe(strobe),
    .txPoint(txPoint), .samplePoint(samplePoint), .cfgErr(cfgErr)
  );

  canBtData #(.ALLOW_VOTE(ALLOW_VOTE)) data_i (
    .clk(clk), .rstN(rstN), .tqEn(tqEn), .rxLine(rxLine), .strobe(strobe),
    .edgeSeen(edgeSeen), .rxBit(rxBit)
  );
endmodule

// File: tb/canBitTiming_tb_top.sv
module canBitTiming_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tqEn = 1'b0, rxLine = 1'b1, busIdle = 1'b1, txDominant = 1'b0;
  logic       tripleSample = 1'b0;
  logic [4:0] ps1Len = 5'd8;
  logic [3:0] ps2Len = 4'd4;
  logic [2:0] sjwLen = 3'd1;
  logic       rxBit, txPoint, samplePoint, cfgErr;

  int total = 0, bad = 0;
  logic obsSp, obsTx, obsRb;
  int spT[4], txT[4];
  logic spV[4];
  int nSp, nTx;

  always #4 clk = ~clk;

  canBitTiming dut_i (
    .clk(clk), .rstN(rstN), .tqEn(tqEn), .rxLine(rxLine), .busIdle(busIdle),
    .txDominant(txDominant), .tripleSample(tripleSample), .ps1Len(ps1Len),
    .ps2Len(ps2Len), .sjwLen(sjwLen), .rxBit(rxBit), .txPoint(txPoint),
    .samplePoint(samplePoint), .cfgErr(cfgErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setCfg(input int p1, input int p2, input int s);
    ps1Len = 5'(p1);
    ps2Len = 4'(p2);
    sjwLen = 3'(s);
  endtask

  // one quantum: line value r is what the closing tqEn sees
  task automatic tick(input logic r);
    @(negedge clk);
    rxLine = r;
    tqEn = 1'b1;
    @(negedge clk);
    tqEn = 1'b0;
    obsSp = samplePoint;
    obsTx = txPoint;
    obsRb = rxBit;
  endtask

  // pat[0] is the hard-sync quantum (tick 0); ticks 1..n follow with busIdle low
  task automatic doRun(input logic [63:0] pat, input int n);
    busIdle = 1'b1;
    tick(1'b1);
    tick(1'b1);
    tick(pat[0]);
    busIdle = 1'b0;
    nSp = 0;
    nTx = 0;
    for (int t = 1; t <= n; t++) begin
      tick(pat[t]);
      if (obsSp && nSp < 4) begin spT[nSp] = t; spV[nSp] = obsRb; nSp++; end
      if (obsTx && nTx < 4) begin txT[nTx] = t; nTx++; end
    end
  endtask

  function automatic logic [63:0] quietPat();
    logic [63:0] p;
    p = '1;
    p[0] = 1'b0;
    return p;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] pat;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 samplePoint", int'(samplePoint), 0);
    check("R11 txPoint", int'(txPoint), 0);
    check("R11 rxBit", int'(rxBit), 1);
    check("R1 cfgErr legal", int'(cfgErr), 0);
    rstN = 1'b1;

    // R2 / R3 / R1: period sweep over every legal segment pair
    for (int p1 = 4; p1 <= 16; p1++) begin
      for (int p2 = 2; p2 <= 8; p2++) begin
        setCfg(p1, p2, 1);
        @(negedge clk);
        check("R1 cfgErr low", int'(cfgErr), 0);
        doRun(quietPat(), 2 * p1 + p2 + 4);
        check("R3 first sample", (nSp > 0) ? spT[0] : -1, p1);
        check("R2 bit start", (nTx > 0) ? txT[0] : -1, p1 + p2);
        check("R2 second sample", (nSp > 1) ? spT[1] : -1, 2 * p1 + p2 + 1);
        check("R4 quiet value", (nSp > 0) ? int'(spV[0]) : -1, 1);
      end
    end

    // R4 / R5: all patterns of the three sampled quanta, both modes
    txDominant = 1'b1;
    setCfg(4, 2, 1);
    for (int tr = 0; tr < 2; tr++) begin
      for (int p = 0; p < 8; p++) begin
        int maj;
        tripleSample = tr[0];
        pat = quietPat();
        pat[2] = p[2];
        pat[3] = p[1];
        pat[4] = p[0];
        maj = (p[2] + p[1] + p[0]) >= 2 ? 1 : 0;
        doRun(pat, 12);
        if (tr == 0) check("R4 single sample", (nSp > 0) ? int'(spV[0]) : -1, int'(p[0]));
        else         check("R5 majority vote", (nSp > 0) ? int'(spV[0]) : -1, maj);
      end
    end
    tripleSample = 1'b0;
    txDominant = 1'b0;

    // R6: edge in sync quantum or phase segment 1 of the second bit
    for (int s = 1; s <= 4; s++) begin
      for (int k = 0; k <= 5; k++) begin
        int t0, expd;
        setCfg(8, 4, s);
        t0 = 13;
        pat = quietPat();
        pat[t0 + k] = 1'b0;
        doRun(pat, 40);
        expd = t0 + 8 + ((k == 0) ? 0 : ((k < s) ? k : s));
        check("R6 lengthened sample", (nSp > 1) ? spT[1] : -1, expd);
      end
    end

    // R7: edge in quantum k of phase segment 2 of the first bit
    for (int s = 1; s <= 4; s++) begin
      for (int k = 1; k <= 6; k++) begin
        int e, expTx, expSp;
        setCfg(6, 6, s);
        pat = quietPat();
        pat[6 + k] = 1'b0;
        doRun(pat, 30);
        e = 6 - k + 1;
        if (e <= s) begin expTx = 6 + k; expSp = 12 + k; end
        else        begin expTx = 12 - s; expSp = 19 - s; end
        check("R7 bit start", (nTx > 0) ? txT[0] : -1, expTx);
        check("R7 next sample", (nSp > 1) ? spT[1] : -1, expSp);
      end
    end

    // R8: second edge before the sample point is ignored
    setCfg(8, 4, 2);
    pat = quietPat();
    pat[14] = 1'b0;
    pat[16] = 1'b0;
    doRun(pat, 40);
    check("R8 one resync", (nSp > 1) ? spT[1] : -1, 22);

    // R8: edge before the first sample after a hard sync is ignored
    pat = quietPat();
    pat[3] = 1'b0;
    doRun(pat, 20);
    check("R8 after hard sync", (nSp > 0) ? spT[0] : -1, 8);

    // R9: no resync while transmitting dominant
    txDominant = 1'b1;
    pat = quietPat();
    pat[16] = 1'b0;
    doRun(pat, 40);
    check("R9 suppressed", (nSp > 1) ? spT[1] : -1, 21);
    txDominant = 1'b0;

    // R1 / R10: each illegal setting
    for (int c = 0; c < 7; c++) begin
      case (c)
        0: setCfg(3, 4, 1);
        1: setCfg(17, 4, 1);
        2: setCfg(8, 1, 1);
        3: setCfg(8, 9, 1);
        4: setCfg(8, 4, 0);
        5: setCfg(8, 8, 5);
        default: setCfg(8, 2, 3);
      endcase
      @(negedge clk);
      check("R1 cfgErr high", int'(cfgErr), 1);
      doRun(quietPat(), 30);
      check("R10 no samples", nSp, 0);
      check("R10 no bit starts", nTx, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule